// File: doc/BRIEF.md
# Host Interrupt Source and Mask Controller

This block collects six event pulses from a modem core and presents them to a host processor through a small shared register window. Each pulse sets a bit in a source register. The host reads that register to poll for events. The host can also let the events drive a single active-low interrupt line, using a read/write enable register whose top bit gates every source at once.

The host acknowledges one event at a time. It does this by writing zero to a reset location reserved for that source. A write of any other value, or a write to an address with no function, changes nothing.

The host bus is synchronous. A write takes effect on the clock edge where the write strobe is high. A read returns its data on `bus_rdata` from the edge where the read strobe is high, and that value holds until the next read.

Top module: `irqc_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the source register (offset 0x50) and the enable register (offset 0x4F) both hold 0x00, and irq_n is 1.
- R2: Each event pulse sets its own source bit on the edge where the pulse is high. The positions are: error on bit 0, TX buffer freed on bit 2, RX buffer filled on bit 3, status change on bit 4, wake on bit 5 and command acknowledge on bit 6. The bit is set whatever the enable register holds.
- R3: The host cannot change the source register by writing to offset 0x50.
- R4: The enable register at offset 0x4F reads back what was written, except that bit 1 always reads 0. Bit 1 of the source register also always reads 0.
- R5: irq_n goes to 0 one clock edge after a source bit n is 1 while enable bit n and enable bit 7 are both 1.
- R6: While enable bit 7 is 0, irq_n stays 1 whatever the other enable bits and the source bits hold.
- R7: Writing 0x00 to offset 0x40+n, for n in {0,2,3,4,5,6}, clears source bit n and leaves the other source bits unchanged.
- R8: The following writes leave the source register unchanged: a nonzero value to a reset location, and any write to offset 0x41.
- R9: If a source's event and a zero write to that source's reset location land on the same edge, the source bit stays 1.
- R10: A read with bus_rd high at an edge loads bus_rdata at that edge, and bus_rdata holds until the next read. Reading the reset locations or any unmapped offset returns 0x00.
- R11: irq_n returns to 1 one clock edge after the last enabled pending source is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_err | input | 1 | Single-cycle error event pulse |
| evt_tx_free | input | 1 | Single-cycle TX buffer freed pulse |
| evt_rx_full | input | 1 | Single-cycle RX buffer filled pulse |
| evt_stat_chg | input | 1 | Single-cycle status change pulse |
| evt_wake | input | 1 | Single-cycle wake-up pulse |
| evt_cmd_ack | input | 1 | Single-cycle command acknowledge pulse |
| bus_addr | input | 7 | Host byte offset |
| bus_wdata | input | 8 | Host write data |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Registered active-low interrupt request |

## Verification
The hardest case to reach from the ports is the collision between an event and its acknowledge, because both inputs must fall on the same edge. The bench therefore carries the event pulses inside the same stimulus entry as the bus write, so that both are driven in one cycle. The latency of irq_n is checked separately, with a directed sequence that samples the line on the edge right after a source becomes enabled and again one edge later. The same directed sequence is used for the edge after the last enabled source is cleared.

// File: rtl/irqc_pkg.sv
// Package: shared constants for the host interrupt controller.
// Assumes a 7-bit byte-offset host window and 8-bit registers.
package irqc_pkg;
    localparam int ADDR_W        = 7;
    localparam int DATA_W        = 8;
    localparam int GLOBAL_EN_BIT = 7;

    localparam logic [ADDR_W-1:0] SRC_REG_ADDR  = 7'h50;
    localparam logic [ADDR_W-1:0] MASK_REG_ADDR = 7'h4F;
    localparam logic [ADDR_W-1:0] CLR_BASE_ADDR = 7'h40;

    // Bit positions of the six sources; bit 1 is not populated
    localparam int IDX_ERR  = 0;
    localparam int IDX_TXF  = 2;
    localparam int IDX_RXF  = 3;
    localparam int IDX_STAT = 4;
    localparam int IDX_WAKE = 5;
    localparam int IDX_CACK = 6;

    localparam logic [DATA_W-1:0] SRC_VALID = 8'h7D;
endpackage

// File: rtl/irqc_src_bank.sv
// Module: irqc_src_bank
// Holds one sticky flag per populated source position. Set has
// priority over clear. Unpopulated positions are tied to zero.
// Assumes set pulses and clear strobes are synchronous to clk.
module irqc_src_bank #(
    parameter int                W     = irqc_pkg::DATA_W,
    parameter logic [W-1:0]      VALID = irqc_pkg::SRC_VALID
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        if (VALID[g]) begin : g_live
            // Sticky flag: event sets, acknowledge clears, set wins
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flags_o[g] <= 1'b0;
                else if (set_i[g])
                    flags_o[g] <= 1'b1;
                else if (clr_i[g])
                    flags_o[g] <= 1'b0;
            end
        end else begin : g_tie
            assign flags_o[g] = 1'b0;
        end
    end
endmodule

// File: rtl/irqc_mask_reg.sv
// Module: irqc_mask_reg
// Host read/write enable register. Bits outside the populated
// source set and the global bit are stored as zero. Also
// produces the effective per-source enable vector.
module irqc_mask_reg #(
    parameter int           W      = irqc_pkg::DATA_W,
    parameter logic [W-1:0] VALID  = irqc_pkg::SRC_VALID,
    parameter int           GBIT   = irqc_pkg::GLOBAL_EN_BIT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] en_o
);
    localparam logic [W-1:0] KEEP = VALID | (W'(1) << GBIT);

    // Store the host value, forcing unpopulated bits low
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_o <= '0;
        else if (we_i)
            mask_o <= wdata_i & KEEP;
    end

    // A source is enabled only with its own bit and the global bit
    always_comb begin
        en_o = mask_o & VALID & {W{mask_o[GBIT]}};
    end
endmodule

// File: rtl/irqc_bus_decode.sv
// Module: irqc_bus_decode
// Decodes the host window: per-source acknowledge strobes (zero
// written to base+n), enable register write, and the read mux.
// Assumes bus strobes are single-cycle and synchronous.
module irqc_bus_decode #(
    parameter int               AW       = irqc_pkg::ADDR_W,
    parameter int               W        = irqc_pkg::DATA_W,
    parameter logic [W-1:0]     VALID    = irqc_pkg::SRC_VALID,
    parameter logic [AW-1:0]    SRC_ADDR = irqc_pkg::SRC_REG_ADDR,
    parameter logic [AW-1:0]    MSK_ADDR = irqc_pkg::MASK_REG_ADDR,
    parameter logic [AW-1:0]    CLR_BASE = irqc_pkg::CLR_BASE_ADDR
) (
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [W-1:0]  src_i,
    input  logic [W-1:0]  mask_i,
    output logic [W-1:0]  clr_o,
    output logic          mask_we_o,
    output logic [W-1:0]  rd_val_o
);
    logic zero_wr;

    // Acknowledge writes only count with an all-zero data byte
    always_comb begin
        zero_wr = wr_i && (wdata_i == '0);
    end

    for (genvar g = 0; g < W; g++) begin : g_clr
        localparam logic [AW-1:0] CLR_ADDR = AW'(CLR_BASE + AW'(g));
        if (VALID[g]) begin : g_live
            assign clr_o[g] = zero_wr && (addr_i == CLR_ADDR);
        end else begin : g_tie
            assign clr_o[g] = 1'b0;
        end
    end

    // Enable register write strobe
    always_comb begin
        mask_we_o = wr_i && (addr_i == MSK_ADDR);
    end

    // Read mux: only the two readable registers return data
    always_comb begin
        if (addr_i == SRC_ADDR)
            rd_val_o = src_i;
        else if (addr_i == MSK_ADDR)
            rd_val_o = mask_i;
        else
            rd_val_o = '0;
    end
endmodule

// File: rtl/irqc_top.sv
// Module: irqc_top
// Host interrupt controller: latches six core events for polling,
// applies per-source and global enables and drives a registered
// active-low request. Assumes event inputs are one-cycle pulses.
module irqc_top #(
    parameter int AW = irqc_pkg::ADDR_W,
    parameter int W  = irqc_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_err,
    input  logic          evt_tx_free,
    input  logic          evt_rx_full,
    input  logic          evt_stat_chg,
    input  logic          evt_wake,
    input  logic          evt_cmd_ack,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    input  logic          bus_wr,
    input  logic          bus_rd,
    output logic [W-1:0]  bus_rdata,
    output logic          irq_n
);
    import irqc_pkg::*;

    logic [W-1:0] evt_vec;
    logic [W-1:0] clr_vec;
    logic [W-1:0] src_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] en_vec;
    logic [W-1:0] rd_val;
    logic         mask_we;

    // Place each event pulse on its register bit position
    always_comb begin
        evt_vec           = '0;
        evt_vec[IDX_ERR]  = evt_err;
        evt_vec[IDX_TXF]  = evt_tx_free;
        evt_vec[IDX_RXF]  = evt_rx_full;
        evt_vec[IDX_STAT] = evt_stat_chg;
        evt_vec[IDX_WAKE] = evt_wake;
        evt_vec[IDX_CACK] = evt_cmd_ack;
    end

    irqc_bus_decode #(.AW(AW), .W(W)) i_dec (
        .wr_i     (bus_wr),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .src_i    (src_q),
        .mask_i   (mask_q),
        .clr_o    (clr_vec),
        .mask_we_o(mask_we),
        .rd_val_o (rd_val)
    );

    irqc_src_bank #(.W(W)) i_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_vec),
        .clr_i  (clr_vec),
        .flags_o(src_q)
    );

    irqc_mask_reg #(.W(W)) i_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (mask_we),
        .wdata_i(bus_wdata),
        .mask_o (mask_q),
        .en_o   (en_vec)
    );

    // Registered request: low while any enabled source is pending
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_n <= 1'b1;
        else
            irq_n <= ~|(src_q & en_vec);
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_val;
    end
endmodule

// File: rtl/irqc_chk.sv
// Module: irqc_chk
// Property checker for irqc_top, attached through bind below.
module irqc_chk #(
    parameter int           AW    = irqc_pkg::ADDR_W,
    parameter int           W     = irqc_pkg::DATA_W,
    parameter logic [W-1:0] VALID = irqc_pkg::SRC_VALID
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic [W-1:0]  bus_wdata,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [W-1:0]  bus_rdata,
    input logic          irq_n,
    input logic [W-1:0]  evt_vec,
    input logic [W-1:0]  src_vec,
    input logic [W-1:0]  mask_vec
);
    import irqc_pkg::*;

    // R1: reset leaves everything idle
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (irq_n && src_vec == '0 && mask_vec == '0));

    // R6: global bit low keeps the request high
    a_r6_global_off: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_vec[GLOBAL_EN_BIT] |=> irq_n);

    // R5: an enabled pending source pulls the request low next edge
    a_r5_irq_assert: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_vec[GLOBAL_EN_BIT] && |(src_vec & mask_vec & VALID)) |=> !irq_n);

    // R4: bit 1 of both readable registers is never returned as 1
    a_r4_bit1_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == SRC_REG_ADDR || bus_addr == MASK_REG_ADDR))
        |=> !bus_rdata[1]);

    // R8: writes with nonzero data never drop a pending source
    a_r8_nonzero_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wdata != '0) |=> ((src_vec & $past(src_vec)) == $past(src_vec)));

    for (genvar g = 0; g < W; g++) begin : g_src
        if (VALID[g]) begin : g_live
            localparam logic [AW-1:0] CA = AW'(CLR_BASE_ADDR + AW'(g));
            // R2: an event always sets its bit
            a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
                evt_vec[g] |=> src_vec[g]);
            // R7: zero write to its reset location clears the bit
            a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr == CA && bus_wdata == '0 && !evt_vec[g])
                |=> !src_vec[g]);
        end
    end
endmodule

bind irqc_top irqc_chk #(.AW(AW), .W(W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .irq_n    (irq_n),
    .evt_vec  (evt_vec),
    .src_vec  (src_q),
    .mask_vec (mask_q)
);

// File: tb/test_irqc_top.sv
// Bench for irqc_top: a vector table walked by one loop, then
// directed tests for latency and mid-run reset.
module test_irqc_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] evt = '0;
    logic [6:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    irqc_top i_irqc_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_err     (evt[0]),
        .evt_tx_free (evt[1]),
        .evt_rx_full (evt[2]),
        .evt_stat_chg(evt[3]),
        .evt_wake    (evt[4]),
        .evt_cmd_ack (evt[5]),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_rdata   (bus_rdata),
        .irq_n       (irq_n)
    );

    // op: 0 none, 1 write, 2 read. evt bits: err,txf,rxf,stat,wake,cack
    typedef struct packed {
        logic [1:0] op;
        logic [6:0] addr;
        logic [7:0] data;
        logic [5:0] evt;
        logic [7:0] exp_rd;
        logic       exp_irq;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VEC [NV] = '{
        '{2'd2, 7'h50, 8'h00, 6'h00, 8'h00, 1'b1}, // R1 source clear
        '{2'd2, 7'h4F, 8'h00, 6'h00, 8'h00, 1'b1}, // R1 mask clear
        '{2'd0, 7'h00, 8'h00, 6'h01, 8'h00, 1'b1}, // R2 err while masked
        '{2'd2, 7'h50, 8'h00, 6'h00, 8'h01, 1'b1}, // R2 polled
        '{2'd1, 7'h4F, 8'h01, 6'h00, 8'h00, 1'b1}, // R6 no global
        '{2'd2, 7'h4F, 8'h00, 6'h00, 8'h01, 1'b1}, // R4 readback
        '{2'd1, 7'h4F, 8'h81, 6'h00, 8'h00, 1'b0}, // R5 enabled
        '{2'd1, 7'h41, 8'h00, 6'h00, 8'h00, 1'b0}, // R8 hole offset
        '{2'd1, 7'h40, 8'h55, 6'h00, 8'h00, 1'b0}, // R8 nonzero ack
        '{2'd2, 7'h50, 8'h00, 6'h00, 8'h01, 1'b0}, // R8 still set
        '{2'd1, 7'h40, 8'h00, 6'h00, 8'h00, 1'b1}, // R7 ack err
        '{2'd2, 7'h50, 8'h00, 6'h00, 8'h00, 1'b1}, // R7 cleared
        '{2'd0, 7'h00, 8'h00, 6'h06, 8'h00, 1'b1}, // R2 txf+rxf, not enabled
        '{2'd2, 7'h50, 8'h00, 6'h00, 8'h0C, 1'b1}, // R2 positions 2,3
        '{2'd1, 7'h4F, 8'hFF, 6'h00, 8'h00, 1'b0}, // R5 all on
        '{2'd2, 7'h4F, 8'h00, 6'h00, 8'hFD, 1'b0}, // R4 bit1 low
        '{2'd1, 7'h50, 8'h00, 6'h00, 8'h00, 1'b0}, // R3 write src
        '{2'd2, 7'h50, 8'h00, 6'h00, 8'h0C, 1'b0}, // R3 unchanged
        '{2'd1, 7'h43, 8'h00, 6'h00, 8'h00, 1'b0}, // R7 ack rxf
        '{2'd2, 7'h50, 8'h00, 6'h00, 8'h04, 1'b0}, // R7 only txf left
        '{2'd1, 7'h42, 8'h00, 6'h00, 8'h00, 1'b1}, // R11 last cleared
        '{2'd0, 7'h00, 8'h00, 6'h38, 8'h00, 1'b0}, // R2 stat,wake,cack
        '{2'd2, 7'h50, 8'h00, 6'h00, 8'h70, 1'b0}, // R2 positions 4..6
        '{2'd1, 7'h4F, 8'h7F, 6'h00, 8'h00, 1'b1}, // R6 global off
        '{2'd1, 7'h4F, 8'h90, 6'h00, 8'h00, 1'b0}, // R5 stat only
        '{2'd1, 7'h44, 8'h00, 6'h00, 8'h00, 1'b1}, // R11 enabled gone
        '{2'd2, 7'h50, 8'h00, 6'h00, 8'h60, 1'b1}, // R7 others kept
        '{2'd2, 7'h46, 8'h00, 6'h00, 8'h00, 1'b1}, // R10 reset loc reads 0
        '{2'd2, 7'h4F, 8'h00, 6'h00, 8'h90, 1'b1}, // R4 readback
        '{2'd1, 7'h45, 8'h00, 6'h10, 8'h00, 1'b1}, // R9 collision
        '{2'd2, 7'h50, 8'h00, 6'h00, 8'h60, 1'b1}, // R9 wake held
        '{2'd1, 7'h45, 8'h00, 6'h00, 8'h00, 1'b1}, // R7 ack wake
        '{2'd1, 7'h46, 8'h00, 6'h00, 8'h00, 1'b1}, // R7 ack cack
        '{2'd2, 7'h50, 8'h00, 6'h00, 8'h00, 1'b1}  // R7 all clear
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle with optional events, then one idle cycle
    task automatic apply(input logic [1:0] op, input logic [6:0] a,
                         input logic [7:0] d, input logic [5:0] e);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = (op == 2'd1);
        bus_rd    = (op == 2'd2);
        evt       = e;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
        evt    = '0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].op, VEC[i].addr, VEC[i].data, VEC[i].evt);
            if (VEC[i].op == 2'd2)
                check($sformatf("vec%0d rdata (R2/R3/R4/R7/R8/R9/R10)", i),
                      bus_rdata, VEC[i].exp_rd);
            check($sformatf("vec%0d irq_n (R5/R6/R11)", i),
                  {7'd0, irq_n}, {7'd0, VEC[i].exp_irq});
        end

        // R5 latency: request follows the source by exactly one edge
        apply(2'd1, 7'h4F, 8'hC0, 6'h00);
        @(negedge clk);
        evt = 6'h20;
        @(negedge clk);
        evt = '0;
        check("R5 irq_n one edge after event", {7'd0, irq_n}, 8'h01);
        @(negedge clk);
        check("R5 irq_n two edges after event", {7'd0, irq_n}, 8'h00);

        // R11 latency: request releases one edge after the clear
        @(negedge clk);
        bus_addr = 7'h46; bus_wdata = 8'h00; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R11 irq_n at clear edge", {7'd0, irq_n}, 8'h00);
        @(negedge clk);
        check("R11 irq_n one edge later", {7'd0, irq_n}, 8'h01);

        // R1 reset in mid-run with an enabled pending source
        apply(2'd1, 7'h4F, 8'h81, 6'h01);
        check("R1 pre-reset irq_n low", {7'd0, irq_n}, 8'h00);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 irq_n during reset", {7'd0, irq_n}, 8'h01);
        rst_n = 1'b1;
        apply(2'd2, 7'h50, 8'h00, 6'h00);
        check("R1 source after reset", bus_rdata, 8'h00);
        apply(2'd2, 7'h4F, 8'h00, 6'h00);
        check("R1 mask after reset", bus_rdata, 8'h00);
        check("R1 irq_n idle", {7'd0, irq_n}, 8'h01);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule